// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a register-mapped watchdog for a system controller. Software loads a 10-bit start count, clears the halt bit, and then keeps the watchdog alive by writing the reload register before the countdown runs out. An external slow tick-enable pulse sets the pace of the countdown. The tick generator and the platform reset network are outside this block.

The first time the counter runs out, a first-timeout status flag is set. An interrupt request is raised if it is enabled. The counter then reloads and counts down again. If it runs out a second time while the first-timeout flag is still set, the block records a second timeout. Unless the no-reboot gate is set, it also emits a one-cycle reset request and sets a boot-cause flag. Clearing the first-timeout flag while servicing the watchdog restores the full two-countdown margin.

Top module: `wdt_two_stage`

The bus is one halfword wide and has a lane enable for each byte. Writes take effect at the clock edge, and reads are combinational from `bus_addr`.

Register map (halfword index on `bus_addr`):

| Index | Register | Fields |
|-------|----------|--------|
| 0 | reload / count | any write reloads; read returns count in bits [9:0] |
| 1 | start count | bits [9:0] |
| 2 | control | bit 11 = halt, bit 0 = no-reboot |
| 3 | interrupt enable | bit 13 |
| 4 | status 1 | bit 3 = first timeout |
| 5 | status 2 | bit 1 = second timeout, bit 2 = boot cause |

## Requirements
- R1: After reset the count reads 0, the start count reads 0x0010, the control register reads 0x0801 (halt bit 11 = 1, no-reboot bit 0 = 1), the interrupt-enable register reads 0, all status bits read 0, and `irq` and `rst_req` are low.
- R2: The start count (index 1, bits [9:0]) keeps only 10 bits. A write whose resulting value is 0 to 3 is discarded, and the previous value stays.
- R3: Any write to index 0 loads the count with the start count. Reading index 0 returns the live count. When a reload write and a tick come in the same cycle, the reload wins.
- R4: While control bit 11 (halt) is 1, ticks leave the count unchanged. Bit 11 reads back as written.
- R5: While running, each tick lowers the count by one. A tick that arrives at a count of 0 is an expiry, and it reloads the start count. Starting from a reload value N, the expiry is therefore the (N+1)th tick.
- R6: An expiry while status-1 bit 3 is clear sets that bit. `irq` equals status-1 bit 3 AND interrupt-enable bit 13.
- R7: An expiry while status-1 bit 3 is set sets status-2 bit 1. If the no-reboot bit is 0, it also sets status-2 bit 2 and drives `rst_req` high for exactly one cycle, the cycle after the tick.
- R8: With control bit 0 (no-reboot) at 1, a second expiry still sets status-2 bit 1, but `rst_req` stays low and status-2 bit 2 stays clear.
- R9: Status bits are write-one-to-clear, and each bit is cleared only by its own 1. After status-1 bit 3 is cleared, two full countdowns are needed again before a second timeout.
- R10: Byte lane 0 (`bus_be[0]`) covers data bits [7:0] and lane 1 covers bits [15:8]. A write changes only the fields in its enabled lanes. The start-count legality check applies to the merged value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Halfword register index |
| bus_be | input | 2 | Byte lane enables |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| tick | input | 1 | Slow countdown enable pulse |
| irq | output | 1 | First-timeout interrupt request |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
A wrong count shows up at once in a readback of index 0 after the next tick. It also shifts the expiry by whole ticks, and so it moves the moment the status and `irq` outputs rise. A stage flag that is stuck or lost changes which expiry produces `rst_req`: either a reset comes one countdown early, or it never comes. The sweep therefore samples the count, both status words and `rst_req` after every tick, across several start counts and both no-reboot settings. This places any such fault within one tick of its cause.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_RELOAD = 3'd0;
  localparam logic [ADDR_W-1:0] A_START  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd2;
  localparam logic [ADDR_W-1:0] A_IRQEN  = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT1  = 3'd4;
  localparam logic [ADDR_W-1:0] A_STAT2  = 3'd5;

  localparam int B_HALT   = 11;
  localparam int B_NOREB  = 0;
  localparam int B_IRQEN  = 13;
  localparam int B_FIRST  = 3;
  localparam int B_SECOND = 1;
  localparam int B_BOOT   = 2;

  // Combine old register contents with new data, byte lane by byte lane.
  function automatic logic [DATA_W-1:0] lane_merge(input logic [DATA_W-1:0] old_v,
                                                   input logic [DATA_W-1:0] new_v,
                                                   input logic [1:0]        be);
    logic [DATA_W-1:0] r;
    r[7:0]  = be[0] ? new_v[7:0]  : old_v[7:0];
    r[15:8] = be[1] ? new_v[15:8] : old_v[15:8];
    return r;
  endfunction

  function automatic logic start_legal(input logic [DATA_W-1:0] v, input int unsigned min_v);
    return 32'(v) >= min_v;
  endfunction
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int CNT_W     = 10,
  parameter int START_RST = 16,
  parameter int MIN_START = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              sts_first,
  input  logic              sts_second,
  input  logic              sts_boot,
  output logic [CNT_W-1:0]  start_val,
  output logic              halt,
  output logic              no_reboot,
  output logic              irq_en,
  output logic              reload_wr,
  output logic              clr_first,
  output logic              clr_second,
  output logic              clr_boot
);
  localparam int PAD_W = DATA_W - CNT_W;

  logic              wr_any;
  logic [DATA_W-1:0] start_wide;
  logic [DATA_W-1:0] start_merged;
  logic [DATA_W-1:0] start_trim;

  assign wr_any       = bus_wr && (bus_be != 2'b00);
  assign start_wide   = {{PAD_W{1'b0}}, start_val};
  assign start_merged = lane_merge(start_wide, bus_wdata, bus_be);
  assign start_trim   = {{PAD_W{1'b0}}, start_merged[CNT_W-1:0]};

  assign reload_wr  = wr_any && (bus_addr == A_RELOAD);
  assign clr_first  = bus_wr && bus_be[0] && (bus_addr == A_STAT1) && bus_wdata[B_FIRST];
  assign clr_second = bus_wr && bus_be[0] && (bus_addr == A_STAT2) && bus_wdata[B_SECOND];
  assign clr_boot   = bus_wr && bus_be[0] && (bus_addr == A_STAT2) && bus_wdata[B_BOOT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_val <= CNT_W'(START_RST);
      halt      <= 1'b1;
      no_reboot <= 1'b1;
      irq_en    <= 1'b0;
    end else if (wr_any) begin
      case (bus_addr)
        A_START: begin
          if (start_legal(start_trim, MIN_START)) start_val <= start_merged[CNT_W-1:0];
        end
        A_CTRL: begin
          if (bus_be[1]) halt      <= bus_wdata[B_HALT];
          if (bus_be[0]) no_reboot <= bus_wdata[B_NOREB];
        end
        A_IRQEN: begin
          if (bus_be[1]) irq_en <= bus_wdata[B_IRQEN];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_RELOAD: bus_rdata = {{PAD_W{1'b0}}, cnt};
      A_START:  bus_rdata = start_wide;
      A_CTRL: begin
        bus_rdata[B_HALT]  = halt;
        bus_rdata[B_NOREB] = no_reboot;
      end
      A_IRQEN:  bus_rdata[B_IRQEN] = irq_en;
      A_STAT1:  bus_rdata[B_FIRST] = sts_first;
      A_STAT2: begin
        bus_rdata[B_SECOND] = sts_second;
        bus_rdata[B_BOOT]   = sts_boot;
      end
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             halt,
  input  logic             reload,
  input  logic [CNT_W-1:0] start_val,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  logic run_tick;
  logic at_zero;

  // A reload write takes priority over a tick in the same cycle.
  assign run_tick = tick && !halt && !reload;
  assign at_zero  = (cnt == '0);
  assign expire   = run_tick && at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (reload)    cnt <= start_val;
    else if (run_tick)  cnt <= at_zero ? start_val : cnt - 1'b1;
  end
endmodule

// File: rtl/wdt_stage.sv
module wdt_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic no_reboot,
  input  logic clr_first,
  input  logic clr_second,
  input  logic clr_boot,
  output logic first_evt,
  output logic second_evt,
  output logic sts_first,
  output logic sts_second,
  output logic sts_boot,
  output logic rst_req
);
  logic fire;

  assign first_evt  = expire && !sts_first;
  assign second_evt = expire && sts_first;
  assign fire       = second_evt && !no_reboot;

  // A new event takes priority over a clear that arrives in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_first  <= 1'b0;
      sts_second <= 1'b0;
      sts_boot   <= 1'b0;
      rst_req    <= 1'b0;
    end else begin
      sts_first  <= first_evt  || (sts_first  && !clr_first);
      sts_second <= second_evt || (sts_second && !clr_second);
      sts_boot   <= fire       || (sts_boot   && !clr_boot);
      rst_req    <= fire;
    end
  end
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
  import wdt_pkg::*;
#(
  parameter int CNT_W     = 10,
  parameter int START_RST = 16,
  parameter int MIN_START = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick,
  output logic              irq,
  output logic              rst_req
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] start_val;
  logic halt, no_reboot, irq_en, reload_wr;
  logic clr_first, clr_second, clr_boot;
  logic expire, first_evt, second_evt;
  logic sts_first, sts_second, sts_boot;

  wdt_regs #(.CNT_W(CNT_W), .START_RST(START_RST), .MIN_START(MIN_START)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt(cnt),
    .sts_first(sts_first), .sts_second(sts_second), .sts_boot(sts_boot),
    .start_val(start_val), .halt(halt), .no_reboot(no_reboot), .irq_en(irq_en),
    .reload_wr(reload_wr), .clr_first(clr_first), .clr_second(clr_second), .clr_boot(clr_boot)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .tick(tick), .halt(halt), .reload(reload_wr),
    .start_val(start_val), .cnt(cnt), .expire(expire)
  );

  wdt_stage u_stage (
    .clk(clk), .rst_n(rst_n), .expire(expire), .no_reboot(no_reboot),
    .clr_first(clr_first), .clr_second(clr_second), .clr_boot(clr_boot),
    .first_evt(first_evt), .second_evt(second_evt),
    .sts_first(sts_first), .sts_second(sts_second), .sts_boot(sts_boot), .rst_req(rst_req)
  );

  assign irq = sts_first && irq_en;
endmodule

// File: rtl/wdt_two_stage_chk.sv
module wdt_two_stage_chk #(
  parameter int CNT_W     = 10,
  parameter int MIN_START = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] start_val,
  input logic             halt,
  input logic             no_reboot,
  input logic             reload_wr,
  input logic             first_evt,
  input logic             second_evt,
  input logic             sts_first,
  input logic             rst_req
);
  // R7
  rst_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> ($past(second_evt) && !$past(no_reboot)));

  // R7
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R8
  noreboot_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    no_reboot |=> !rst_req);

  // R2
  start_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_val >= CNT_W'(MIN_START));

  // R4
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !reload_wr) |=> $stable(cnt));

  // R3
  reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_wr |=> (cnt == $past(start_val)));

  // R6
  first_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    first_evt |=> sts_first);

  // R9
  second_needs_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    second_evt |-> sts_first);
endmodule

bind wdt_two_stage wdt_two_stage_chk #(.CNT_W(CNT_W), .MIN_START(MIN_START)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .start_val(start_val), .halt(halt),
  .no_reboot(no_reboot), .reload_wr(reload_wr), .first_evt(first_evt),
  .second_evt(second_evt), .sts_first(sts_first), .rst_req(rst_req)
);

// File: tb/wdt_two_stage_bench.sv
module wdt_two_stage_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [1:0]  bus_be = 2'b00;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        tick = 1'b0;
  logic        irq;
  logic        rst_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // model state derived from the requirements
  int m_cnt, m_start;
  bit m_halt, m_noreb, m_first, m_second, m_boot, m_rst;

  always #10 clk = ~clk;

  wdt_two_stage u_wdt_two_stage (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick(tick), .irq(irq), .rst_req(rst_req)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 2'b00;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rd_chk(input logic [2:0] a, input int exp, input string tag);
    logic [15:0] d;
    rd(a, d);
    chk(d == 16'(exp), tag, int'(d), exp);
  endtask

  // one tick pulse, model update, then checks of rst_req, count and status
  task automatic do_tick();
    m_rst = 1'b0;
    if (!m_halt) begin
      if (m_cnt == 0) begin
        m_cnt = m_start;
        if (!m_first) m_first = 1'b1;
        else begin
          m_second = 1'b1;
          if (!m_noreb) begin m_boot = 1'b1; m_rst = 1'b1; end
        end
      end else m_cnt = m_cnt - 1;
    end
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    #1 chk(rst_req == m_rst, "R7/R8 rst_req after tick", int'(rst_req), int'(m_rst));
    @(negedge clk);
    #1 chk(rst_req == 1'b0, "R7 rst_req one cycle", int'(rst_req), 0);
    rd_chk(3'd0, m_cnt, "R5 count after tick");
    rd_chk(3'd4, m_first ? 16'h0008 : 16'h0000, "R6 status1");
    rd_chk(3'd5, (m_second ? 2 : 0) + (m_boot ? 4 : 0), "R7/R8 status2");
  endtask

  task automatic clear_all();
    wr(3'd4, 16'h0008, 2'b01);
    wr(3'd5, 16'h0006, 2'b01);
    m_first = 0; m_second = 0; m_boot = 0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired before bench completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_chk(3'd0, 16'h0000, "R1 count");
    rd_chk(3'd1, 16'h0010, "R1 start");
    rd_chk(3'd2, 16'h0801, "R1 control");
    rd_chk(3'd3, 16'h0000, "R1 irq enable");
    rd_chk(3'd4, 16'h0000, "R1 status1");
    rd_chk(3'd5, 16'h0000, "R1 status2");
    #1 chk(irq == 1'b0 && rst_req == 1'b0, "R1 outputs", int'({irq, rst_req}), 0);

    // R2 start-count legality sweep
    m_start = 16;
    for (int v = 0; v < 16; v++) begin
      wr(3'd1, 16'(v), 2'b11);
      if (v >= 4) m_start = v;
      rd_chk(3'd1, m_start, "R2 start write");
    end
    wr(3'd1, 16'hFFFF, 2'b11);
    rd_chk(3'd1, 16'h03FF, "R2 ten-bit field");
    // R10 lane merge
    wr(3'd1, 16'h0055, 2'b01);
    rd_chk(3'd1, 16'h0355, "R10 low lane only");
    wr(3'd1, 16'h0100, 2'b10);
    rd_chk(3'd1, 16'h0155, "R10 high lane only");
    wr(3'd1, 16'h0002, 2'b01);
    rd_chk(3'd1, 16'h0102, "R10 merged legal");
    wr(3'd1, 16'h0000, 2'b10);
    rd_chk(3'd1, 16'h0102, "R2 R10 merged value 2 discarded");
    wr(3'd2, 16'h0000, 2'b01);
    rd_chk(3'd2, 16'h0800, "R10 control low lane keeps halt");
    wr(3'd2, 16'h0001, 2'b11);
    rd_chk(3'd2, 16'h0001, "R4 halt readback 0");
    wr(3'd2, 16'h0801, 2'b11);
    rd_chk(3'd2, 16'h0801, "R4 halt readback 1");

    // R4 halted count holds
    m_halt = 1; m_noreb = 1; m_first = 0; m_second = 0; m_boot = 0;
    wr(3'd1, 16'd6, 2'b11); m_start = 6;
    wr(3'd0, 16'h0000, 2'b11); m_cnt = 6;
    rd_chk(3'd0, 6, "R3 reload loads start");
    for (int i = 0; i < 3; i++) do_tick();
    rd_chk(3'd0, 6, "R4 halted count");

    // R3 reload wins over simultaneous tick
    wr(3'd2, 16'h0001, 2'b11); m_halt = 0;
    do_tick(); do_tick();
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 16'h0; bus_be = 2'b01; tick = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 2'b00; tick = 1'b0;
    m_cnt = 6;
    rd_chk(3'd0, 6, "R3 reload beats tick");

    // R5..R8 sweep over start counts, no-reboot setting and irq enable
    for (int n = 4; n < 10; n++) begin
      m_noreb = n[0];
      wr(3'd2, 16'h0800 | 16'(m_noreb), 2'b11); m_halt = 1;
      wr(3'd1, 16'(n), 2'b11); m_start = n;
      wr(3'd3, (n >= 7) ? 16'h2000 : 16'h0000, 2'b10);
      clear_all();
      wr(3'd0, 16'h0000, 2'b11); m_cnt = n;
      wr(3'd2, 16'(m_noreb), 2'b11); m_halt = 0;
      for (int t = 0; t < 2 * (n + 1); t++) begin
        do_tick();
        if (t == n) begin
          #1 chk(irq == (n >= 7), "R6 irq after first expiry", int'(irq), int'(n >= 7));
        end
      end
      rd_chk(3'd5, m_noreb ? 16'h0002 : 16'h0006, "R7/R8 final status2");
    end

    // R9 servicing restores two countdowns; W1C clears only its own bit
    m_noreb = 0;
    wr(3'd2, 16'h0800, 2'b11); m_halt = 1;
    wr(3'd1, 16'd5, 2'b11); m_start = 5;
    clear_all();
    wr(3'd0, 16'h0000, 2'b11); m_cnt = 5;
    wr(3'd2, 16'h0000, 2'b11); m_halt = 0;
    for (int t = 0; t < 6; t++) do_tick();
    rd_chk(3'd4, 16'h0008, "R9 first set");
    wr(3'd4, 16'h0008, 2'b01); m_first = 0;
    rd_chk(3'd4, 16'h0000, "R9 first cleared");
    for (int t = 0; t < 6; t++) do_tick();
    rd_chk(3'd5, 16'h0000, "R9 no second after service");
    for (int t = 0; t < 6; t++) do_tick();
    rd_chk(3'd5, 16'h0006, "R9 second after two countdowns");
    wr(3'd5, 16'h0002, 2'b01); m_second = 0;
    rd_chk(3'd5, 16'h0004, "R9 W1C own bit only");
    wr(3'd5, 16'h0004, 2'b10);
    rd_chk(3'd5, 16'h0004, "R9 R10 clear on disabled lane ignored");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule